// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block passes data words from a write clock domain to an unrelated read clock domain through a small storage array. Its depth is a power of two set by a parameter. Occupancy is tracked by binary pointers. Each pointer crosses to the other domain in Gray code through a two-stage synchroniser, and each flag is derived from the local pointer and the synchronised copy of the remote one.

A mode input is sampled only while the master reset is asserted, and it selects one of two read behaviours. In standard mode a read strobe moves the next word into the output register. The read status output works as an active-low empty flag, and the write status output works as an active-low full flag. In fall-through mode the head word appears on the output without a read strobe, and the read strobe consumes it. The read status output is then active-low "data valid", and the write status output is active-low "can accept". In this mode the output register adds one word of capacity.

Three further active-low outputs report the fill level: almost-full, almost-empty and half-full. The almost-full threshold comes from a full offset m and the almost-empty threshold from an empty offset n. The master reset sets both offsets to 7. They can be rewritten through a small load port while the FIFO is empty. The partial reset empties the FIFO but keeps the mode and the offsets.

Top module: `dcfifo_pflags`

## Requirements
- R1: After either reset, paFullN=1, paEmptyN=0 and halfFullN=1. In standard mode wrFlag=1 and rdFlag=0. In fall-through mode wrFlag=0 and rdFlag=1.
- R2: In standard mode, a rdEn pulse with rdFlag=1 loads the oldest word into dout on that read-clock edge, and words leave in write order. A rdEn while rdFlag=0 leaves dout unchanged.
- R3: The FIFO holds D words in standard mode and D+1 in fall-through mode (D = 2^ADDR_W). The full indication is wrFlag=0 in standard mode and wrFlag=1 in fall-through mode. A write while full is discarded.
- R4: In fall-through mode the oldest word appears on dout with rdFlag=0 and no rdEn. dout holds until a rdEn consumes the word. When the last word is consumed, rdFlag returns to 1.
- R5: In standard mode, with no reads since reset, paFullN goes to 0 once D-m words have been written, and it is 0 whenever the FIFO is full.
- R6: In fall-through mode, with no reads since reset, paFullN goes to 0 once D+1-m words have been written.
- R7: paEmptyN is registered on the read clock. It is 0 when the stored count is at most n in standard mode, or at most n+1 in fall-through mode (the count includes the output word).
- R8: halfFullN goes to 0 on the write-clock edge that takes the memory occupancy above D/2. That is after D/2+1 writes in standard mode and D/2+2 in fall-through mode. It returns to 1 once reads bring the occupancy to D/2 or less.
- R9: Master reset sets m=n=7. An offLoad pulse writes offVal into m when offSel=0, or into n when offSel=1.
- R10: An offLoad is ignored unless the memory is empty and no write is taking place in the same cycle.
- R11: Partial reset empties the FIFO and keeps m, n and the mode. modeSel is not sampled during partial reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| masterRst | input | 1 | Master reset, active high, sampled by both clocks |
| partialRst | input | 1 | Partial reset, active high, sampled by both clocks |
| modeSel | input | 1 | 1 selects fall-through mode, sampled during master reset |
| wrEn | input | 1 | Write strobe |
| din | input | DATA_W | Write data |
| offLoad | input | 1 | Offset load strobe (write clock) |
| offSel | input | 1 | 0 = full offset m, 1 = empty offset n |
| offVal | input | ADDR_W | Offset value |
| wrFlag | output | 1 | Full (standard, active low) or can-accept (fall-through, active low) |
| paFullN | output | 1 | Programmable almost-full, active low |
| halfFullN | output | 1 | Half-full, active low |
| rdEn | input | 1 | Read strobe |
| dout | output | DATA_W | Read data register |
| rdFlag | output | 1 | Empty (standard, active low) or data-valid (fall-through, active low) |
| paEmptyN | output | 1 | Programmable almost-empty, active low |

## Verification
The FIFO is filled one word at a time with no reads, once in each mode and once with reprogrammed offsets. At every step the bench compares the flags with thresholds worked out from D, m and n. This shows whether the one-word shift of fall-through mode is present, and whether the offsets in use are the defaults or the loaded values. Draining the FIFO checks word order and the release of half-full. Extra writes when full and extra reads when empty show whether overflow and underflow are blocked. An offset load with a word stored, and a partial reset with modeSel changed, show whether the load guard works and what partial reset keeps.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  // strobes from control to the storage datapath
  typedef struct packed {
    logic memWrite;   // write domain: store din at wrAddr
    logic outLoad;    // read domain: load output register from rdAddr
  } fifoStrb_t;
endpackage

// File: rtl/dcfifo_mem.sv
module dcfifo_mem
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rdRst,
  input  fifoStrb_t         strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.memWrite) store[wrAddr] <= din;
  end

  always_ff @(posedge rdClk) begin
    if (rdRst)             dout <= '0;
    else if (strb.outLoad) dout <= store[rdAddr];
  end
endmodule

// File: rtl/dcfifo_ctrl.sv
module dcfifo_ctrl
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int OFF_DEFAULT = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              masterRst,
  input  logic              partialRst,
  input  logic              modeSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              offLoad,
  input  logic              offSel,
  input  logic [ADDR_W-1:0] offVal,
  output fifoStrb_t         strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              wrFlag,
  output logic              rdFlag,
  output logic              paFullN,
  output logic              paEmptyN,
  output logic              halfFullN,
  output logic              fwftWr,
  output logic              fwftRd
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);
  localparam logic [PW-1:0] HALF_P  = PW'((1 << ADDR_W) / 2);
  localparam logic [ADDR_W-1:0] OFF_INIT = ADDR_W'(OFF_DEFAULT);

  function automatic logic [PW-1:0] grayToBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic anyRst;
  assign anyRst = masterRst | partialRst;

  // ---------------- write domain ----------------
  logic [PW-1:0] wrBin, wrGray, rdGrayS1, rdGrayS2, rdBinW;
  logic [PW-1:0] wrCount, wrCountNext;
  logic [ADDR_W-1:0] offFull, offEmpty;
  logic fullR, pafR, wrHalf, wrDo, idle;

  assign rdBinW      = grayToBin(rdGrayS2);
  assign wrCount     = wrBin - rdBinW;
  assign wrDo        = wrEn & ~fullR;
  assign wrCountNext = wrCount + PW'(wrDo);
  assign idle        = (wrCount == '0) & ~wrEn;

  always_ff @(posedge wrClk) begin
    if (masterRst) begin
      fwftWr   <= modeSel;
      offFull  <= OFF_INIT;
      offEmpty <= OFF_INIT;
    end else if (offLoad && idle && !partialRst) begin
      if (offSel) offEmpty <= offVal;
      else        offFull  <= offVal;
    end
  end

  always_ff @(posedge wrClk) begin
    if (anyRst) begin
      wrBin    <= '0;
      wrGray   <= '0;
      rdGrayS1 <= '0;
      rdGrayS2 <= '0;
      fullR    <= 1'b0;
      pafR     <= 1'b0;
      wrHalf   <= 1'b0;
    end else begin
      rdGrayS1 <= rdGray;
      rdGrayS2 <= rdGrayS1;
      if (wrDo) begin
        wrBin  <= wrBin + 1'b1;
        wrGray <= (wrBin + 1'b1) ^ ((wrBin + 1'b1) >> 1);
      end
      fullR  <= (wrCountNext == DEPTH_P);
      pafR   <= (wrCountNext >= (DEPTH_P - {1'b0, offFull}));
      wrHalf <= (wrCountNext > HALF_P);
    end
  end

  assign wrAddr        = wrBin[ADDR_W-1:0];
  assign strb.memWrite = wrDo;
  assign wrFlag        = fwftWr ? fullR : ~fullR;
  assign paFullN       = ~pafR;

  // ---------------- read domain ----------------
  logic [PW-1:0] rdBin, rdGray, wrGrayS1, wrGrayS2, wrBinR;
  logic [PW-1:0] memCount, memNext, levelNext;
  logic outValid, validNext, loadNow, memHas, paeLow, rdHalf;

  assign wrBinR   = grayToBin(wrGrayS2);
  assign memCount = wrBinR - rdBin;
  assign memHas   = (memCount != '0);

  always_comb begin
    if (fwftRd) begin
      loadNow   = memHas & (~outValid | rdEn);
      validNext = loadNow | (outValid & ~rdEn);
    end else begin
      loadNow   = memHas & rdEn;
      validNext = 1'b0;
    end
  end

  assign memNext   = memCount - PW'(loadNow);
  assign levelNext = memNext + PW'(validNext);

  always_ff @(posedge rdClk) begin
    if (masterRst) fwftRd <= modeSel;
  end

  always_ff @(posedge rdClk) begin
    if (anyRst) begin
      rdBin    <= '0;
      rdGray   <= '0;
      wrGrayS1 <= '0;
      wrGrayS2 <= '0;
      outValid <= 1'b0;
      paeLow   <= 1'b1;
      rdHalf   <= 1'b0;
    end else begin
      wrGrayS1 <= wrGray;
      wrGrayS2 <= wrGrayS1;
      if (loadNow) begin
        rdBin  <= rdBin + 1'b1;
        rdGray <= (rdBin + 1'b1) ^ ((rdBin + 1'b1) >> 1);
      end
      outValid <= validNext;
      // offEmpty is quasi-static: only changes while the FIFO is idle
      paeLow   <= (levelNext <= ({1'b0, offEmpty} + PW'(fwftRd)));
      rdHalf   <= (memNext > HALF_P);
    end
  end

  assign rdAddr       = rdBin[ADDR_W-1:0];
  assign strb.outLoad = loadNow;
  assign rdFlag       = fwftRd ? ~outValid : memHas;
  assign paEmptyN     = ~paeLow;

  // set by the write side, released once both sides see D/2 or less
  assign halfFullN = ~(wrHalf | rdHalf);
endmodule

// File: rtl/dcfifo_pflags.sv
module dcfifo_pflags
  import dcfifo_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int OFF_DEFAULT = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              masterRst,
  input  logic              partialRst,
  input  logic              modeSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] din,
  input  logic              offLoad,
  input  logic              offSel,
  input  logic [ADDR_W-1:0] offVal,
  output logic              wrFlag,
  output logic              paFullN,
  output logic              halfFullN,
  input  logic              rdEn,
  output logic [DATA_W-1:0] dout,
  output logic              rdFlag,
  output logic              paEmptyN
);
  fifoStrb_t         strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic              fwftWr, fwftRd;

  dcfifo_ctrl #(.ADDR_W(ADDR_W), .OFF_DEFAULT(OFF_DEFAULT)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .partialRst(partialRst),
    .modeSel(modeSel), .wrEn(wrEn), .rdEn(rdEn), .offLoad(offLoad),
    .offSel(offSel), .offVal(offVal), .strb(strb), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .wrFlag(wrFlag), .rdFlag(rdFlag), .paFullN(paFullN),
    .paEmptyN(paEmptyN), .halfFullN(halfFullN), .fwftWr(fwftWr), .fwftRd(fwftRd)
  );

  dcfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wrClk(wrClk), .rdClk(rdClk), .rdRst(masterRst | partialRst), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .din(din), .dout(dout)
  );
endmodule

// File: rtl/dcfifo_pflags_chk.sv
module dcfifo_pflags_chk
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              anyRst,
  input logic              rdEn,
  input logic              wrFlag,
  input logic              rdFlag,
  input logic              paFullN,
  input logic              paEmptyN,
  input logic [DATA_W-1:0] dout,
  input fifoStrb_t         strb,
  input logic              fwftWr,
  input logic              fwftRd
);
  logic wrFullSeen, rdEmptySeen;
  assign wrFullSeen  = fwftWr ? wrFlag : ~wrFlag;
  assign rdEmptySeen = ~fwftRd & ~rdFlag;

  // R1: reset leaves almost-full inactive
  assert_wr_reset_R1: assert property (@(posedge wrClk) $past(anyRst) |-> paFullN);

  // R1: reset leaves almost-empty active
  assert_rd_reset_R1: assert property (@(posedge rdClk) $past(anyRst) |-> !paEmptyN);

  // R3: no storage write while full is reported
  assert_no_overflow_R3: assert property (@(posedge wrClk) disable iff (anyRst)
    wrFullSeen |-> !strb.memWrite);

  // R5: full always implies almost-full
  assert_full_paf_R5: assert property (@(posedge wrClk) disable iff (anyRst)
    wrFullSeen |-> !paFullN);

  // R2: no output load while empty in standard mode
  assert_no_underflow_R2: assert property (@(posedge rdClk) disable iff (anyRst)
    rdEmptySeen |-> !strb.outLoad);

  // R4: fall-through head word holds until consumed
  assert_fwft_hold_R4: assert property (@(posedge rdClk) disable iff (anyRst)
    (fwftRd && !rdFlag && !rdEn) |=> $stable(dout));
endmodule

bind dcfifo_pflags dcfifo_pflags_chk #(.DATA_W(DATA_W)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .anyRst(masterRst | partialRst), .rdEn(rdEn),
  .wrFlag(wrFlag), .rdFlag(rdFlag), .paFullN(paFullN), .paEmptyN(paEmptyN),
  .dout(dout), .strb(strb), .fwftWr(fwftWr), .fwftRd(fwftRd)
);

// File: tb/dcfifo_pflags_bench.sv
`timescale 1ns/100ps
module dcfifo_pflags_bench;
  localparam int AW = 4;
  localparam int DW = 16;

  logic wrClk = 1'b0, rdClk = 1'b0;
  always #2 wrClk = ~wrClk;     // 250 MHz
  always #3.5 rdClk = ~rdClk;

  logic masterRst = 1'b1, partialRst = 1'b0, modeSel = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, offLoad = 1'b0, offSel = 1'b0;
  logic [DW-1:0] din = '0;
  logic [AW-1:0] offVal = '0;
  logic wrFlag, paFullN, halfFullN, rdFlag, paEmptyN;
  logic [DW-1:0] dout;

  int total = 0, bad = 0;
  bit done = 1'b0;

  dcfifo_pflags #(.DATA_W(DW), .ADDR_W(AW)) u_dcfifo_pflags (
    .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .partialRst(partialRst),
    .modeSel(modeSel), .wrEn(wrEn), .din(din), .offLoad(offLoad), .offSel(offSel),
    .offVal(offVal), .wrFlag(wrFlag), .paFullN(paFullN), .halfFullN(halfFullN),
    .rdEn(rdEn), .dout(dout), .rdFlag(rdFlag), .paEmptyN(paEmptyN)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // wait until both synchronisers and flag registers have settled
  task automatic settle();
    repeat (5) @(posedge rdClk);
    repeat (4) @(posedge wrClk);
    @(negedge wrClk);
  endtask

  task automatic doReset(input bit master, input bit mode);
    @(negedge wrClk);
    masterRst = master; partialRst = !master; modeSel = mode;
    repeat (4) @(posedge rdClk);
    @(negedge wrClk);
    masterRst = 1'b0; partialRst = 1'b0;
    settle();
  endtask

  task automatic pushWord(input logic [DW-1:0] d);
    @(negedge wrClk); wrEn = 1'b1; din = d;
    @(negedge wrClk); wrEn = 1'b0;
    settle();
  endtask

  task automatic popWord();
    @(negedge rdClk); rdEn = 1'b1;
    @(negedge rdClk); rdEn = 1'b0;
    settle();
  endtask

  task automatic loadOff(input bit sel, input logic [AW-1:0] v);
    @(negedge wrClk); offLoad = 1'b1; offSel = sel; offVal = v;
    @(negedge wrClk); offLoad = 1'b0;
    settle();
  endtask

  task automatic testStandard();
    doReset(1'b1, 1'b0);
    check("R1", "std wrFlag", wrFlag, 1);
    check("R1", "std rdFlag", rdFlag, 0);
    check("R1", "paFullN", paFullN, 1);
    check("R1", "paEmptyN", paEmptyN, 0);
    check("R1", "halfFullN", halfFullN, 1);
    for (int k = 1; k <= 16; k++) begin
      pushWord(DW'(16'h100 + k));
      if (k == 7) check("R7", "std pae at 7", paEmptyN, 0);
      if (k == 8) begin
        check("R7", "std pae at 8", paEmptyN, 1);
        check("R5", "std paf at 8", paFullN, 1);
        check("R8", "std hf at 8", halfFullN, 1);
      end
      if (k == 9) begin
        check("R5", "std paf at 9", paFullN, 0);
        check("R8", "std hf at 9", halfFullN, 0);
      end
      if (k == 15) check("R3", "std not full at 15", wrFlag, 1);
      if (k == 16) check("R3", "std full at 16", wrFlag, 0);
    end
    pushWord(16'hDEAD);
    for (int i = 1; i <= 16; i++) begin
      popWord();
      check("R2", "std read order", dout, 32'h100 + i);
      if (i == 7) check("R8", "std hf at 9 left", halfFullN, 0);
      if (i == 8) check("R8", "std hf at 8 left", halfFullN, 1);
    end
    check("R2", "std empty after drain", rdFlag, 0);
    popWord();
    check("R2", "std read when empty keeps dout", dout, 32'h110);
    check("R3", "std overflow word dropped", rdFlag, 0);
  endtask

  task automatic testFallThrough();
    doReset(1'b1, 1'b1);
    check("R1", "fwft wrFlag", wrFlag, 0);
    check("R1", "fwft rdFlag", rdFlag, 1);
    for (int k = 1; k <= 17; k++) begin
      pushWord(DW'(16'h200 + k));
      if (k == 1) begin
        check("R4", "fwft valid no read", rdFlag, 0);
        check("R4", "fwft head word", dout, 32'h201);
      end
      if (k == 8) check("R7", "fwft pae at 8", paEmptyN, 0);
      if (k == 9) begin
        check("R7", "fwft pae at 9", paEmptyN, 1);
        check("R6", "fwft paf at 9", paFullN, 1);
        check("R8", "fwft hf at 9", halfFullN, 1);
      end
      if (k == 10) begin
        check("R6", "fwft paf at 10", paFullN, 0);
        check("R8", "fwft hf at 10", halfFullN, 0);
      end
      if (k == 16) check("R3", "fwft not full at 16", wrFlag, 0);
      if (k == 17) check("R3", "fwft full at 17", wrFlag, 1);
    end
    pushWord(16'hBEEF);
    for (int i = 1; i <= 17; i++) begin
      check("R4", "fwft read order", dout, 32'h200 + i);
      popWord();
    end
    check("R4", "fwft no data after drain", rdFlag, 1);
    check("R3", "fwft overflow word dropped", dout, 32'h211);
  endtask

  task automatic testOffsets();
    doReset(1'b1, 1'b0);
    loadOff(1'b0, 4'd3);
    loadOff(1'b1, 4'd2);
    pushWord(16'h301);
    loadOff(1'b0, 4'd1);   // memory not empty: must be ignored (R10)
    for (int k = 2; k <= 13; k++) begin
      pushWord(DW'(16'h300 + k));
      if (k == 2) check("R9", "loaded n=2 pae at 2", paEmptyN, 0);
      if (k == 3) check("R9", "loaded n=2 pae at 3", paEmptyN, 1);
      if (k == 12) check("R10", "paf at 12", paFullN, 1);
      if (k == 13) check("R10", "m stays 3, paf at 13", paFullN, 0);
    end
  endtask

  task automatic testPartial();
    doReset(1'b0, 1'b1);   // modeSel high must not switch the mode
    check("R11", "mode kept wrFlag", wrFlag, 1);
    check("R11", "emptied rdFlag", rdFlag, 0);
    check("R11", "emptied paEmptyN", paEmptyN, 0);
    check("R11", "emptied paFullN", paFullN, 1);
    for (int k = 1; k <= 13; k++) begin
      pushWord(DW'(16'h400 + k));
      if (k == 12) check("R11", "offset kept paf at 12", paFullN, 1);
      if (k == 13) check("R11", "offset kept paf at 13", paFullN, 0);
    end
    doReset(1'b1, 1'b0);
    for (int k = 1; k <= 9; k++) begin
      pushWord(DW'(16'h500 + k));
      if (k == 8) check("R9", "default m paf at 8", paFullN, 1);
      if (k == 9) check("R9", "default m paf at 9", paFullN, 0);
    end
  endtask

  initial begin
    testStandard();
    testFallThrough();
    testOffsets();
    testPartial();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule